// File: doc/BRIEF.md
# Scatter-Gather Address Translation Cache

This block turns addresses arriving from a PCI-side requester into physical memory addresses, one 8 kB page at a time. Each bus page maps on its own to any physical page, so a run of adjacent bus pages can land on pages scattered through memory. The low thirteen address bits select a byte inside the page and pass straight through. The high bits, the bus page number, are looked up in a small fully associative cache of recent translations.

When the page is in the cache, the translated address comes back on the next cycle. When it is not, the block stops taking requests. It reads one 64-bit mapping entry from a table in main memory at `table base + page number * 8`. It stores the entry in the slot named by a circular replacement pointer and then answers. An entry whose valid flag is clear produces an error response and is not stored. Software can load the table base and can empty the whole cache with a single-cycle pulse.

Top module: `sg_xlate_cache`

## Requirements
- R1: In a successful response, `rsp_addr[12:0]` equals `req_addr[12:0]` of the accepted request, and `rsp_addr[31:13]` equals the physical page number of the mapping, taken from bits [31:13] of the 64-bit table entry.
- R2: A request whose bus page is held in the cache gets `rsp_valid` high, with `rsp_err` low, on the cycle after it is accepted, and no memory read is issued.
- R3: A request that misses raises `mem_rd_valid` for exactly one cycle, on the cycle after acceptance, with `mem_rd_addr` equal to the table base plus the bus page number (`req_addr[31:13]`) times 8.
- R4: After a miss, `rsp_valid` rises on the cycle after `mem_rd_data_valid` is seen, and a later request to the same page hits.
- R5: A table entry with bit 0 clear is invalid. It gives a response with `rsp_err` high, is not stored, and does not move the replacement pointer, so a repeat request to that page misses again.
- R6: The cache holds eight translations. Fills go to slots in circular order and wrap after the eighth. After nine distinct valid fills, the first page misses and the other eight hit.
- R7: A one-cycle pulse on `inv_all` empties every slot, so the next request to any page that was cached misses.
- R8: `req_ready` is low from the cycle after a miss is accepted until the response cycle. Requests offered in that time are ignored, and only one table read is outstanding.
- R9: While reset is held, `req_ready` is high, `rsp_valid` and `mem_rd_valid` are low, and the cache is empty.
- R10: A write on `base_wr_en` changes the table base for later misses only. Translations already cached keep answering with their stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_err | output | 1 | Mapping entry was invalid |
| rsp_addr | output | 32 | Translated physical address |
| base_wr_en | input | 1 | Load the table base |
| base_wr_data | input | 32 | New table base, 8-byte aligned |
| inv_all | input | 1 | Empty every cache slot |
| mem_rd_valid | output | 1 | Table entry read request, one cycle |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_data_valid | input | 1 | Table entry returned |
| mem_rd_data | input | 64 | Table entry: bit 0 valid, bits [31:13] physical page |

## Verification
The assertions make three assumptions about the inputs. Memory answers each table read exactly once, and only after the read has been issued. The table base is a multiple of eight. A request held during a stall is simply not accepted, rather than counted as a second outstanding miss. The stimulus respects all three: a single scripted memory responder returns one entry per read after one to three idle cycles, only aligned bases are written, and junk requests offered during a fetch are withdrawn before the block becomes ready again. Page numbers in the replacement sweep are chosen to avoid the invalid-entry pattern, so the expected set of resident pages follows from the circular order alone.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

   typedef enum logic [1:0] {
      SGX_IDLE  = 2'd0,
      SGX_ISSUE = 2'd1,
      SGX_WAIT  = 2'd2
   } sgx_state_e;

endpackage

// File: rtl/sgx_rr_ptr.sv
module sgx_rr_ptr #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] ptr_q;

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr_q <= '0;
            else if (advance) ptr_q <= ptr_q + IDX_W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr_q <= '0;
            else if (advance) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + IDX_W'(1);
         end
      end
   endgenerate

   assign ptr = ptr_q;

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (ptr == (($past(ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr) + IDX_W'(1)))); // R6

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr)); // R5

endmodule

// File: rtl/sgx_tag_array.sv
module sgx_tag_array #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 19,
   parameter int DATA_W  = 19,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              inv_all,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);

   logic [ENTRIES-1:0] vld_vec;
   logic [ENTRIES-1:0] match;
   logic [DATA_W-1:0]  dat_arr [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic              vld_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;
      logic              sel;

      assign sel = fill_en && (fill_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld_q <= 1'b0;
         else if (inv_all) vld_q <= 1'b0;
         else if (sel)     vld_q <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            dat_q <= '0;
         end else if (sel) begin
            tag_q <= fill_tag;
            dat_q <= fill_data;
         end
      end

      assign vld_vec[g] = vld_q;
      assign match[g]   = vld_q && (tag_q == lk_tag);
      assign dat_arr[g] = dat_q;
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) lk_data = lk_data | dat_arr[i];
      end
   end

   assign lk_hit = |match;

   AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R6

   AST_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld_vec == '0)); // R7

   AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !inv_all) |=> ($countones(vld_vec) >= 1)); // R4

endmodule

// File: rtl/sgx_fetch_ctl.sv
module sgx_fetch_ctl
   import sgx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic lk_hit,
   input  logic mem_rd_data_valid,
   output logic req_ready,
   output logic acc_any,
   output logic acc_hit,
   output logic acc_miss,
   output logic mem_issue,
   output logic data_take
);

   sgx_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         SGX_IDLE:  if (req_valid && !lk_hit) st_d = SGX_ISSUE;
         SGX_ISSUE: st_d = SGX_WAIT;
         SGX_WAIT:  if (mem_rd_data_valid) st_d = SGX_IDLE;
         default:   st_d = SGX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SGX_IDLE;
      else        st_q <= st_d;
   end

   assign req_ready = (st_q == SGX_IDLE);
   assign acc_any   = req_ready && req_valid;
   assign acc_hit   = acc_any && lk_hit;
   assign acc_miss  = acc_any && !lk_hit;
   assign mem_issue = (st_q == SGX_ISSUE);
   assign data_take = (st_q == SGX_WAIT) && mem_rd_data_valid;

   AST_ISSUE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_miss |=> mem_issue); // R3

   AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_issue |=> (!mem_issue && !req_ready)); // R8

   AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |=> !mem_issue); // R2

endmodule

// File: rtl/sg_xlate_cache.sv
module sg_xlate_cache #(
   parameter int BUS_AW      = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BITS   = 13,
   parameter int ENTRIES     = 8,
   parameter int ENTRY_BYTES = 8,
   parameter int MEM_DW      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_AW-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [PA_W-1:0]   rsp_addr,
   input  logic              base_wr_en,
   input  logic [PA_W-1:0]   base_wr_data,
   input  logic              inv_all,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rd_data_valid,
   input  logic [MEM_DW-1:0] mem_rd_data
);

   localparam int VPN_W     = BUS_AW - PAGE_BITS;
   localparam int PFN_W     = PA_W - PAGE_BITS;
   localparam int IDX_W     = $clog2(ENTRIES);
   localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert ((1 << ENT_SHIFT) == ENTRY_BYTES) else $error("ENTRY_BYTES must be a power of two");
      assert (PA_W >= VPN_W + ENT_SHIFT) else $error("table offset does not fit PA_W");
      assert (MEM_DW > PA_W) else $error("entry word must be wider than PA_W");
      assert (PAGE_BITS > 1 && BUS_AW > PAGE_BITS) else $error("bad page split");
   end

   logic              lk_hit, acc_any, acc_hit, acc_miss, mem_issue, data_take;
   logic [PFN_W-1:0]  lk_pfn;
   logic [IDX_W-1:0]  rr_idx;
   logic [VPN_W-1:0]  vpn_q;
   logic [PAGE_BITS-1:0] off_q;
   logic [PA_W-1:0]   base_q;
   logic              ent_ok, fill_en;
   logic [PFN_W-1:0]  ent_pfn;
   logic              rsp_valid_q, rsp_err_q;
   logic [PA_W-1:0]   rsp_addr_q;
   logic              unused_bits;

   assign ent_ok      = mem_rd_data[0];
   assign ent_pfn     = mem_rd_data[PA_W-1:PAGE_BITS];
   assign unused_bits = ^{mem_rd_data[MEM_DW-1:PA_W], mem_rd_data[PAGE_BITS-1:1]};
   assign fill_en     = data_take && ent_ok;

   sgx_fetch_ctl u_ctl (
      .clk               (clk),
      .rst_n             (rst_n),
      .req_valid         (req_valid),
      .lk_hit            (lk_hit),
      .mem_rd_data_valid (mem_rd_data_valid),
      .req_ready         (req_ready),
      .acc_any           (acc_any),
      .acc_hit           (acc_hit),
      .acc_miss          (acc_miss),
      .mem_issue         (mem_issue),
      .data_take         (data_take)
   );

   sgx_tag_array #(
      .ENTRIES (ENTRIES),
      .TAG_W   (VPN_W),
      .DATA_W  (PFN_W),
      .IDX_W   (IDX_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (req_addr[BUS_AW-1:PAGE_BITS]),
      .lk_hit    (lk_hit),
      .lk_data   (lk_pfn),
      .inv_all   (inv_all),
      .fill_en   (fill_en),
      .fill_idx  (rr_idx),
      .fill_tag  (vpn_q),
      .fill_data (ent_pfn)
   );

   sgx_rr_ptr #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (fill_en),
      .ptr     (rr_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          base_q <= '0;
      else if (base_wr_en) base_q <= base_wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q <= '0;
         off_q <= '0;
      end else if (acc_any) begin
         vpn_q <= req_addr[BUS_AW-1:PAGE_BITS];
         off_q <= req_addr[PAGE_BITS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_addr_q  <= '0;
      end else begin
         rsp_valid_q <= acc_hit || data_take;
         if (acc_hit) begin
            rsp_err_q  <= 1'b0;
            rsp_addr_q <= {lk_pfn, req_addr[PAGE_BITS-1:0]};
         end else if (data_take) begin
            rsp_err_q  <= !ent_ok;
            rsp_addr_q <= ent_ok ? {ent_pfn, off_q} : '0;
         end
      end
   end

   assign mem_rd_valid = mem_issue;
   assign mem_rd_addr  = base_q + ({{(PA_W - VPN_W){1'b0}}, vpn_q} << ENT_SHIFT);
   assign rsp_valid    = rsp_valid_q;
   assign rsp_err      = rsp_err_q;
   assign rsp_addr     = rsp_addr_q;

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_addr[PAGE_BITS-1:0] == off_q)); // R1

   AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready); // R8

   AST_MISS_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      acc_miss |=> !rsp_valid); // R4

endmodule

// File: tb/sg_xlate_cache_tb.sv
`timescale 1ns/1ps
module sg_xlate_cache_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_addr;
   logic        base_wr_en = 1'b0;
   logic [31:0] base_wr_data = '0;
   logic        inv_all = 1'b0;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_data_valid = 1'b0;
   logic [63:0] mem_rd_data = '0;

   int vectors = 0;
   int fails   = 0;
   logic [31:0] base_cur = '0;

   always #5 clk = ~clk;

   sg_xlate_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
      .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .inv_all(inv_all),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [18:0] pfn_of(input int vpn, input logic [31:0] base);
      return 19'((vpn * 13) + 3 + int'(base >> 16));
   endfunction

   function automatic bit ent_good(input int vpn);
      return (vpn % 16) != 15;
   endfunction

   // Request that should hit: response next cycle, no table read (R2, R1)
   task automatic do_hit(input int vpn, input int off, input logic [18:0] pfn);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = {19'(vpn), 13'(off)};
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1, "R2 hit rsp_valid", 64'(rsp_valid), 64'd1);
      chk(mem_rd_valid === 1'b0, "R2 no read on hit", 64'(mem_rd_valid), 64'd0);
      chk(rsp_err === 1'b0, "R2 hit rsp_err", 64'(rsp_err), 64'd0);
      chk(rsp_addr === {pfn, 13'(off)}, "R1 hit address", 64'(rsp_addr), 64'({pfn, 13'(off)}));
   endtask

   // Request that should miss: table read, stall, fill (R3, R4, R5, R8)
   task automatic do_miss(input int vpn, input int off, input int lat, input bit junk);
      logic [31:0] ea;
      logic [18:0] pfn;
      bit good;
      ea   = base_cur + 32'(vpn * 8);
      pfn  = pfn_of(vpn, base_cur);
      good = ent_good(vpn);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = {19'(vpn), 13'(off)};
      @(negedge clk);
      req_valid = junk;
      req_addr  = junk ? {19'(vpn + 4000), 13'h155} : req_addr;
      chk(rsp_valid === 1'b0, "R4 no early rsp", 64'(rsp_valid), 64'd0);
      chk(mem_rd_valid === 1'b1, "R3 read issued", 64'(mem_rd_valid), 64'd1);
      chk(mem_rd_addr === ea, "R3 entry address", 64'(mem_rd_addr), 64'(ea));
      chk(req_ready === 1'b0, "R8 stall", 64'(req_ready), 64'd0);
      for (int k = 0; k < lat; k++) begin
         @(negedge clk);
         chk(mem_rd_valid === 1'b0 && req_ready === 1'b0 && rsp_valid === 1'b0,
             "R8 one fetch, stalled", {61'd0, mem_rd_valid, req_ready, rsp_valid}, 64'd0);
      end
      req_valid         = 1'b0;
      mem_rd_data_valid = 1'b1;
      mem_rd_data       = (64'(pfn) << 13) | 64'(good) | (64'hA5 << 40);
      @(negedge clk);
      mem_rd_data_valid = 1'b0;
      mem_rd_data       = '0;
      chk(rsp_valid === 1'b1, "R4 rsp after data", 64'(rsp_valid), 64'd1);
      chk(rsp_err === !good, "R5 error flag", 64'(rsp_err), 64'(!good));
      if (good)
         chk(rsp_addr === {pfn, 13'(off)}, "R1 miss address", 64'(rsp_addr), 64'({pfn, 13'(off)}));
      chk(req_ready === 1'b1, "R8 ready after rsp", 64'(req_ready), 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [31:0] old_base;
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
      chk(rsp_valid === 1'b0, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk(mem_rd_valid === 1'b0, "R9 reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
      rst_n = 1'b1;
      base_wr_en   = 1'b1;
      base_wr_data = 32'h0040_0000;
      @(negedge clk);
      base_wr_en = 1'b0;
      base_cur   = 32'h0040_0000;

      // R9: empty after reset, so the first lookups miss; fill slots 0..7
      for (int v = 0; v < 8; v++) do_miss(v, (v * 977 + 5) % 8192, (v % 3) + 1, v == 3);
      for (int v = 0; v < 8; v++) do_hit(v, (v * 311 + 8000) % 8192, pfn_of(v, base_cur));

      // R6: ninth page evicts the first
      do_miss(8, 17, 2, 1'b0);
      for (int v = 1; v < 9; v++) do_hit(v, v * 3, pfn_of(v, base_cur));
      do_miss(0, 8191, 1, 1'b0);

      // R5: invalid entry, not stored, pointer unmoved
      do_miss(15, 100, 1, 1'b0);
      do_miss(15, 101, 3, 1'b1);
      do_miss(16, 0, 2, 1'b0);
      do_hit(3, 4095, pfn_of(3, base_cur));
      do_miss(2, 77, 1, 1'b0);

      // R10: base change does not touch cached translations
      old_base = base_cur;
      @(negedge clk);
      base_wr_en   = 1'b1;
      base_wr_data = 32'h0080_0000;
      @(negedge clk);
      base_wr_en = 1'b0;
      base_cur   = 32'h0080_0000;
      do_hit(16, 1234, pfn_of(16, old_base));
      do_miss(100, 4321, 2, 1'b0);
      do_hit(100, 42, pfn_of(100, base_cur));

      // R7: invalidate empties everything
      @(negedge clk);
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      do_miss(16, 9, 1, 1'b0);
      do_miss(5, 10, 2, 1'b0);
      do_hit(16, 11, pfn_of(16, base_cur));

      // R6: near-exhaustive wrap sweep over twenty distinct pages
      for (int i = 0; i < 20; i++) do_miss(256 + 2 * i, i * 409, (i % 3) + 1, 1'b0);
      for (int i = 12; i < 20; i++) do_hit(256 + 2 * i, i * 7, pfn_of(256 + 2 * i, base_cur));
      do_miss(256 + 2 * 11, 3, 1, 1'b0);

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule